// File: doc/BRIEF.md
# Quantized Int8 Lane-Parallel Adder

This block adds two signed 8-bit tensors one beat at a time. Each beat holds sixteen lanes from operand A and sixteen lanes from operand B. The result is a beat of sixteen signed 8-bit lanes. Each operand has its own zero-point offset, a signed 16-bit fixed-point multiplier and a right-shift amount. With these, each lane is brought into a common 16-bit intermediate domain. The two intermediates are added. The sum is then rescaled into the output domain with a second multiplier and an exponent, shifted by the output zero point, and clamped to a programmable window before it is narrowed to 8 bits.

The configuration inputs are static. They are held constant while beats are in flight. Beats enter and leave on valid/ready streams. The datapath is a four-stage pipeline that accepts one beat per cycle. A stalled output freezes every stage at once. No product or sum in the datapath is wider than 32 bits.

Top module: `qadd_lane_adder`

## Requirements
- R1: For each lane, the intermediate for operand A is computed as follows. Start with t = ((x + cfg_a_off) * 128) * cfg_a_mul, in signed arithmetic. Round it as described in R2, then shift it arithmetically right by 15 and then by cfg_a_rsh (unsigned, 0 to 15). Operand B uses its own cfg_b_* inputs in the same way.
- R2: Before the shift by 15, the rounding adds 16384 when t is zero or positive and 16383 when t is negative. The result is round-to-nearest with ties away from zero, so t = 16384 gives 1 and t = -16384 gives -1.
- R3: Each intermediate saturates symmetrically to the range -32767 to +32767.
- R4: The two intermediates are added and multiplied by cfg_y_mul (signed 16 bits). The product is shifted arithmetically right by (15 - cfg_y_shift), where cfg_y_shift is signed 5 bits in the range -16 to 15. cfg_y_off (signed 8 bits) is then added.
- R5: The result is limited as y = max(cfg_y_min, min(v, cfg_y_max)). When cfg_y_min > cfg_y_max, every lane equals cfg_y_min.
- R6: Lane i of in_a, in_b and out_y occupies bits [8i+7:8i]. Lanes do not interact.
- R7: A beat accepted at a clock edge appears on out_valid after the fourth rising edge, counting the accepting edge, provided out_ready stays high. With out_ready held high the block accepts one beat per cycle.
- R8: While out_valid is high and out_ready is low, out_y and out_valid hold, and in_ready is low. Beats leave in arrival order, none lost and none repeated.
- R9: After reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can take a beat |
| in_a | input | 128 | Operand A lanes, signed 8-bit each |
| in_b | input | 128 | Operand B lanes, signed 8-bit each |
| out_valid | output | 1 | Result beat valid |
| out_ready | input | 1 | Sink takes the result |
| out_y | output | 128 | Result lanes, signed 8-bit each |
| cfg_a_off | input | 8 | Zero-point offset added to A |
| cfg_a_mul | input | 16 | Signed multiplier for A |
| cfg_a_rsh | input | 4 | Extra right shift for A |
| cfg_b_off | input | 8 | Zero-point offset added to B |
| cfg_b_mul | input | 16 | Signed multiplier for B |
| cfg_b_rsh | input | 4 | Extra right shift for B |
| cfg_y_mul | input | 16 | Signed output multiplier |
| cfg_y_shift | input | 5 | Signed output exponent |
| cfg_y_off | input | 8 | Output zero-point offset |
| cfg_y_min | input | 8 | Lower clamp bound |
| cfg_y_max | input | 8 | Upper clamp bound |

## Verification
The internal state is a product or intermediate register per lane plus one valid bit per stage. A wrong value in one of them reaches out_y in the same beat's result, at most three cycles after it forms. A wrong valid bit appears as a missing, extra or early out_valid within four edges of the faulty cycle. Comparing every beat with an arithmetic model, and tracking the cycle in which each beat emerges, therefore exposes a fault in the first beat that passes through the faulty stage.

// File: rtl/qadd_pkg.sv
package qadd_pkg;
   localparam int ACC_W = 32;
   typedef logic signed [ACC_W-1:0] acc_t;

   function automatic acc_t clamp_lo_hi(input acc_t v, input acc_t lo, input acc_t hi);
      acc_t t;
      t = (v > hi) ? hi : v;
      return (t < lo) ? lo : t;
   endfunction
endpackage

// File: rtl/qadd_valid_pipe.sv
module qadd_valid_pipe #(
   parameter int DEPTH = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_valid,
   input  logic out_ready,
   output logic adv,
   output logic out_valid
);
   if (DEPTH < 1) begin : g_bad_depth
      $error("qadd_valid_pipe: DEPTH must be at least 1");
   end

   logic [DEPTH-1:0] vld_q;

   assign adv       = ~vld_q[DEPTH-1] | out_ready;
   assign out_valid = vld_q[DEPTH-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q[0] <= 1'b0;
      end else if (adv) begin
         vld_q[0] <= in_valid;
      end
   end

   for (genvar s = 1; s < DEPTH; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q[s] <= 1'b0;
         end else if (adv) begin
            vld_q[s] <= vld_q[s-1];
         end
      end
   end
endmodule

// File: rtl/qadd_dequant.sv
module qadd_dequant
   import qadd_pkg::*;
#(
   parameter int DW            = 8,
   parameter int MW            = 16,
   parameter int RSW           = 4,
   parameter int PRE_SHIFT     = 7,
   parameter int FRAC          = 15,
   parameter bit ROUND_NEAREST = 1'b1
) (
   input  logic                  clk,
   input  logic                  en,
   input  logic signed [DW-1:0]  x,
   input  logic signed [DW-1:0]  off,
   input  logic signed [MW-1:0]  mul,
   input  logic        [RSW-1:0] rsh,
   output logic signed [MW-1:0]  y
);
   localparam int   SUM_W = DW + 1;
   localparam int   SHL_W = SUM_W + PRE_SHIFT;
   localparam acc_t HALF  = acc_t'(1) <<< (FRAC - 1);
   localparam acc_t SAT   = (acc_t'(1) <<< (MW - 1)) - 1;

   if (SHL_W != MW) begin : g_bad_width
      $error("qadd_dequant: DW + 1 + PRE_SHIFT must equal MW");
   end
   if (2 * MW != ACC_W) begin : g_bad_acc
      $error("qadd_dequant: product must fill the accumulator width");
   end

   logic signed [SUM_W-1:0] sum_off;
   logic signed [SHL_W-1:0] shl;
   acc_t                    prod_d, prod_q;
   acc_t                    nudge, rnd, shr;

   assign sum_off = SUM_W'(x) + SUM_W'(off);
   assign shl     = {sum_off, {PRE_SHIFT{1'b0}}};
   assign prod_d  = acc_t'(shl) * acc_t'(mul);

   always_ff @(posedge clk) begin
      if (en) prod_q <= prod_d;
   end

   if (ROUND_NEAREST) begin : g_round
      assign nudge = prod_q[ACC_W-1] ? (HALF - 1) : HALF;
   end else begin : g_trunc
      assign nudge = '0;
   end

   assign rnd = (prod_q + nudge) >>> FRAC;
   assign shr = rnd >>> rsh;

   always_ff @(posedge clk) begin
      if (en) y <= MW'(clamp_lo_hi(shr, -SAT, SAT));
   end
endmodule

// File: rtl/qadd_requant.sv
module qadd_requant
   import qadd_pkg::*;
#(
   parameter int DW   = 8,
   parameter int MW   = 16,
   parameter int OSW  = 5,
   parameter int FRAC = 15
) (
   input  logic                  clk,
   input  logic                  en,
   input  logic signed [MW-1:0]  a,
   input  logic signed [MW-1:0]  b,
   input  logic signed [MW-1:0]  mul,
   input  logic signed [OSW-1:0] shift,
   input  logic signed [DW-1:0]  off,
   input  logic signed [DW-1:0]  lo,
   input  logic signed [DW-1:0]  hi,
   output logic signed [DW-1:0]  y
);
   localparam logic [OSW-1:0] FRAC_V = OSW'(FRAC);

   if ((1 << OSW) <= FRAC) begin : g_bad_osw
      $error("qadd_requant: OSW too narrow for FRAC");
   end

   acc_t           sum, prod_d, prod_q, shr, biased;
   logic [OSW-1:0] amt;

   assign sum    = acc_t'(a) + acc_t'(b);
   assign prod_d = sum * acc_t'(mul);

   always_ff @(posedge clk) begin
      if (en) prod_q <= prod_d;
   end

   assign amt    = FRAC_V - OSW'(shift);
   assign shr    = prod_q >>> amt;
   assign biased = shr + acc_t'(off);

   always_ff @(posedge clk) begin
      if (en) y <= DW'(clamp_lo_hi(biased, acc_t'(lo), acc_t'(hi)));
   end
endmodule

// File: rtl/qadd_lane_adder.sv
module qadd_lane_adder #(
   parameter int LANES         = 16,
   parameter int DW            = 8,
   parameter int MW            = 16,
   parameter int RSW           = 4,
   parameter int OSW           = 5,
   parameter int PRE_SHIFT     = 7,
   parameter int FRAC          = 15,
   parameter bit ROUND_NEAREST = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   output logic                    in_ready,
   input  logic [LANES*DW-1:0]     in_a,
   input  logic [LANES*DW-1:0]     in_b,
   output logic                    out_valid,
   input  logic                    out_ready,
   output logic [LANES*DW-1:0]     out_y,
   input  logic signed [DW-1:0]    cfg_a_off,
   input  logic signed [MW-1:0]    cfg_a_mul,
   input  logic        [RSW-1:0]   cfg_a_rsh,
   input  logic signed [DW-1:0]    cfg_b_off,
   input  logic signed [MW-1:0]    cfg_b_mul,
   input  logic        [RSW-1:0]   cfg_b_rsh,
   input  logic signed [MW-1:0]    cfg_y_mul,
   input  logic signed [OSW-1:0]   cfg_y_shift,
   input  logic signed [DW-1:0]    cfg_y_off,
   input  logic signed [DW-1:0]    cfg_y_min,
   input  logic signed [DW-1:0]    cfg_y_max
);
   localparam int STAGES = 4;

   if (LANES < 1) begin : g_bad_lanes
      $error("qadd_lane_adder: LANES must be at least 1");
   end

   logic adv;

   qadd_valid_pipe #(.DEPTH(STAGES)) u_vld (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .out_ready (out_ready),
      .adv       (adv),
      .out_valid (out_valid)
   );

   assign in_ready = adv;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic signed [MW-1:0] mid_a, mid_b;
      logic signed [DW-1:0] res;

      qadd_dequant #(
         .DW(DW), .MW(MW), .RSW(RSW), .PRE_SHIFT(PRE_SHIFT),
         .FRAC(FRAC), .ROUND_NEAREST(ROUND_NEAREST)
      ) u_deq_a (
         .clk (clk), .en (adv),
         .x   (in_a[l*DW +: DW]), .off (cfg_a_off),
         .mul (cfg_a_mul), .rsh (cfg_a_rsh), .y (mid_a)
      );

      qadd_dequant #(
         .DW(DW), .MW(MW), .RSW(RSW), .PRE_SHIFT(PRE_SHIFT),
         .FRAC(FRAC), .ROUND_NEAREST(ROUND_NEAREST)
      ) u_deq_b (
         .clk (clk), .en (adv),
         .x   (in_b[l*DW +: DW]), .off (cfg_b_off),
         .mul (cfg_b_mul), .rsh (cfg_b_rsh), .y (mid_b)
      );

      qadd_requant #(.DW(DW), .MW(MW), .OSW(OSW), .FRAC(FRAC)) u_req (
         .clk   (clk), .en (adv),
         .a     (mid_a), .b (mid_b),
         .mul   (cfg_y_mul), .shift (cfg_y_shift), .off (cfg_y_off),
         .lo    (cfg_y_min), .hi (cfg_y_max), .y (res)
      );

      assign out_y[l*DW +: DW] = res;
   end
endmodule

// File: rtl/qadd_lane_adder_chk.sv
module qadd_lane_adder_chk #(
   parameter int LANES = 16,
   parameter int DW    = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 in_valid,
   input logic                 in_ready,
   input logic                 out_valid,
   input logic                 out_ready,
   input logic [LANES*DW-1:0]  out_y,
   input logic signed [DW-1:0] cfg_y_min,
   input logic signed [DW-1:0] cfg_y_max
);
   // R8: a blocked result stays put
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_y)));

   // R8: nothing enters while the output is blocked
   a_r8_no_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);

   // R7: four edges from acceptance to a visible result
   a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) ##1 out_ready ##1 out_ready ##1 out_ready |=> out_valid);

   // R7: an unblocked output never refuses input
   a_r7_ready: assert property (@(posedge clk) disable iff (!rst_n)
      out_ready |-> in_ready);

   for (genvar l = 0; l < LANES; l++) begin : g_clamp
      // R5: each lane within the window when the window is ordered
      a_r5_window: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && (cfg_y_min <= cfg_y_max)) |->
         (($signed(out_y[l*DW +: DW]) >= cfg_y_min) && ($signed(out_y[l*DW +: DW]) <= cfg_y_max)));
   end
endmodule

bind qadd_lane_adder qadd_lane_adder_chk #(.LANES(LANES), .DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_y     (out_y),
   .cfg_y_min (cfg_y_min),
   .cfg_y_max (cfg_y_max)
);

// File: tb/qadd_lane_adder_tb_top.sv
`timescale 1ns/1ps
module qadd_lane_adder_tb_top;
   localparam int L  = 16;
   localparam int W  = L * 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic         in_valid = 1'b0, out_ready = 1'b0;
   logic         in_ready, out_valid;
   logic [W-1:0] in_a = '0, in_b = '0, out_y;
   logic signed [7:0]  a_off = 0, b_off = 0, y_off = 0, y_min = -128, y_max = 127;
   logic signed [15:0] a_mul = 0, b_mul = 0, y_mul = 0;
   logic [3:0]         a_rsh = 0, b_rsh = 0;
   logic signed [4:0]  y_sh = 0;

   qadd_lane_adder dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
      .out_y(out_y), .cfg_a_off(a_off), .cfg_a_mul(a_mul), .cfg_a_rsh(a_rsh),
      .cfg_b_off(b_off), .cfg_b_mul(b_mul), .cfg_b_rsh(b_rsh),
      .cfg_y_mul(y_mul), .cfg_y_shift(y_sh), .cfg_y_off(y_off),
      .cfg_y_min(y_min), .cfg_y_max(y_max)
   );

   int total = 0, bad = 0;
   bit done = 0;
   string cur_req = "R4";
   logic [W-1:0] exp_q[$];

   task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // reference arithmetic from the requirements (R1, R2, R3)
   function automatic int deq(int x, int off, int mul, int rsh);
      int t, r;
      t = (x + off) * 128 * mul;
      r = t + ((t < 0) ? 16383 : 16384);
      r = r >>> 15;
      r = r >>> rsh;
      if (r > 32767) r = 32767;
      if (r < -32767) r = -32767;
      return r;
   endfunction

   // R4, R5
   function automatic int req(int s);
      int p, v;
      p = s * int'(y_mul);
      v = p >>> (15 - int'(y_sh));
      v = v + int'(y_off);
      if (v > int'(y_max)) v = int'(y_max);
      if (v < int'(y_min)) v = int'(y_min);
      return v;
   endfunction

   function automatic logic [W-1:0] model(logic [W-1:0] a, logic [W-1:0] b);
      logic [W-1:0] r;
      for (int l = 0; l < L; l++) begin
         int s;
         s = deq(int'($signed(a[l*8 +: 8])), int'(a_off), int'(a_mul), int'(a_rsh))
           + deq(int'($signed(b[l*8 +: 8])), int'(b_off), int'(b_mul), int'(b_rsh));
         r[l*8 +: 8] = 8'(req(s));  // R6 lane placement
      end
      return r;
   endfunction

   // output monitor, compared every clock (R8)
   bit           held = 0;
   logic [W-1:0] held_y;
   always @(negedge clk) begin
      #1;
      if (rst_n && !done) begin
         if (held) check(out_valid && (out_y == held_y), "R8", out_y, held_y);
         if (out_valid && !out_ready) check(!in_ready, "R8", W'(in_ready), W'(0));
         if (out_valid && out_ready) begin
            if (exp_q.size() == 0) check(1'b0, "R8", out_y, '0);
            else begin
               logic [W-1:0] e;
               e = exp_q.pop_front();
               check(out_y == e, cur_req, out_y, e);
            end
         end
         held   = out_valid && !out_ready;
         held_y = out_y;
      end
   end

   task automatic send(input logic [W-1:0] a, input logic [W-1:0] b, input int pready);
      bit acc = 0;
      while (!acc) begin
         @(negedge clk);
         in_valid  = 1'b1;
         in_a      = a;
         in_b      = b;
         out_ready = (($urandom % 100) < pready);
         #1;
         if (in_ready) begin
            exp_q.push_back(model(a, b));
            acc = 1;
         end
      end
   endtask

   task automatic drain();
      @(negedge clk);
      in_valid  = 1'b0;
      out_ready = 1'b1;
      for (int i = 0; i < 40 && exp_q.size() != 0; i++) @(negedge clk);
      repeat (2) @(negedge clk);
      check(exp_q.size() == 0, "R8", W'(exp_q.size()), W'(0));
   endtask

   function automatic logic [W-1:0] rnd_vec();
      logic [W-1:0] v;
      for (int i = 0; i < W / 32; i++) v[i*32 +: 32] = $urandom;
      return v;
   endfunction

   function automatic logic [W-1:0] fill(logic [7:0] x);
      return {L{x}};
   endfunction

   task automatic stream(input int n, input int pready, input int pgap);
      for (int i = 0; i < n; i++) begin
         if (($urandom % 100) < pgap) begin
            @(negedge clk);
            in_valid = 1'b0;
         end
         send(rnd_vec(), rnd_vec(), pready);
      end
      drain();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      check(!out_valid && in_ready, "R9", W'({out_valid, in_ready}), W'(2'b01));

      // R2: tie rounding, A only, output mirrors the intermediate
      cur_req = "R2";
      a_mul = 128; b_mul = 0; y_mul = 16384; y_sh = 1;
      send({fill(8'h00)} | W'(16'hFF01), fill(8'h00), 100);
      drain();

      // R3: A saturates to +32767, B gives -32767, sum 0
      cur_req = "R3";
      a_off = -128; a_mul = -32768; b_off = -128; b_mul = 32767;
      y_mul = 1; y_sh = 15;
      send(fill(8'h80), fill(8'h80), 100);
      drain();

      // R7: latency with a clear output
      cur_req = "R7";
      a_off = 3; a_mul = 20000; b_off = -5; b_mul = 12000; y_mul = 9000; y_sh = 2; y_off = 4;
      begin
         int k = 0;
         send(rnd_vec(), rnd_vec(), 100);
         @(negedge clk);
         in_valid = 1'b0; out_ready = 1'b1;
         k = 1;
         #1;
         while (!out_valid && k < 10) begin
            @(negedge clk); #1;
            k++;
         end
         check(k == 4, "R7", W'(k), W'(4));
         drain();
      end

      // R7: full rate with ready high, never refused
      begin
         int refused = 0;
         for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_a = rnd_vec(); in_b = rnd_vec(); out_ready = 1'b1;
            #1;
            if (!in_ready) refused++;
            else exp_q.push_back(model(in_a, in_b));
         end
         check(refused == 0, "R7", W'(refused), W'(0));
         drain();
      end

      // R1: per-input extra right shifts
      cur_req = "R1";
      a_off = -7; a_mul = 31000; a_rsh = 3; b_off = 11; b_mul = -17000; b_rsh = 1;
      y_mul = 16384; y_sh = 1; y_off = 0;
      stream(10, 100, 20);

      // R4 and R6: assorted scales and offsets
      cur_req = "R4";
      for (int c = 0; c < 4; c++) begin
         a_off = 8'($urandom); b_off = 8'($urandom);
         a_mul = 16'($urandom); b_mul = 16'($urandom);
         a_rsh = 4'($urandom % 4); b_rsh = 4'($urandom % 4);
         y_mul = 16'($urandom); y_sh = 5'(int'($urandom % 12) - 4); y_off = 8'($urandom);
         stream(8, 100, 10);
      end

      // R5: narrow window, then inverted window
      cur_req = "R5";
      a_off = 0; b_off = 0; a_rsh = 0; b_rsh = 0;
      a_mul = 20000; b_mul = 20000; y_mul = 16384; y_sh = 1; y_off = 0;
      y_min = -10; y_max = 20;
      stream(6, 100, 0);
      y_min = 5; y_max = -5;
      send(rnd_vec(), rnd_vec(), 100);
      drain();
      y_min = -128; y_max = 127;

      // R8: heavy backpressure and gaps
      cur_req = "R8";
      a_mul = 25000; b_mul = -9000; y_mul = 20000; y_sh = 3; y_off = -3;
      stream(60, 40, 30);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule